// File: doc/BRIEF.md
# Programmable Periodic Tick and Square-Wave Generator

This block turns a slow timebase, delivered as single-cycle enable pulses at nominally 32.768 kHz, into a periodic tick whose period is picked by a 4-bit rate code. A single divider tap, chosen by the rate code, times two things. It drives a square-wave pin. It also sets a sticky periodic-event flag. When the interrupt enable is high, that flag becomes an interrupt request.

A free-running binary divider counts timebase pulses. A carry chain marks the pulse on which each of its low-order bit groups rolls over, and the rate code picks one of those carries as the tick. A separate fast square mode sends a signal toggled at timebase rate to the pin. This mode leaves tick timing untouched, so interrupt periods do not depend on which output mode the pin is in. While the divider-run input is low, the counter is held at zero and no ticks occur.

Top module: `prg_rate_gen`

## Requirements
- R1: While reset is asserted and directly after its release, sq_out, pflag and irq are all 0.
- R2: For rate_sel = n, with n from 1 to 15, a tick occurs on every timebase pulse whose 1-based count since div_run rose is a multiple of 2^(n-1). Code 3 gives 4 pulses (122.07 us at 32.768 kHz) and code 15 gives 16384 pulses (500 ms).
- R3: rate_sel = 0 produces no tick, and the divided square wave stays 0.
- R4: pflag goes to 1 in the cycle after a tick, whatever the value of pint_en. A tick wins over a flag_clr given in the same cycle.
- R5: pflag stays 1 until a flag_clr is seen without a coincident tick. It reads 0 in the next cycle.
- R6: irq is 1 exactly when pflag is 1 and pint_en is 1. It falls in the same cycle that pflag falls or pint_en drops.
- R7: With sq_fast = 0, sq_out toggles on every tick, so the square period is two tick periods. Its first level after divider start is 0.
- R8: While div_run is 0, the divider is held at zero, no ticks occur, sq_out reads 0 from the next cycle on, and pflag keeps its value.
- R9: With sq_fast = 1, sq_out toggles on every timebase pulse while div_run is 1. Tick and flag timing are the same as with sq_fast = 0.
- R10: Cycles in which tb_en is 0 do not advance the divider, so the tick period is counted in timebase pulses, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle timebase pulse (nominally 32.768 kHz) |
| div_run | input | 1 | Divider run; 0 holds the divider at zero |
| rate_sel | input | 4 | Rate code; 0 = off, n = tick every 2^(n-1) pulses |
| pint_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Clear strobe for the periodic flag |
| sq_fast | input | 1 | Drives the pin at timebase rate instead of the divided tap |
| sq_out | output | 1 | Square-wave pin level |
| pflag | output | 1 | Sticky periodic event flag |
| irq | output | 1 | Gated periodic interrupt request |

## Verification
The bench uses the default 4-bit rate code, which gives a 14-bit divider. This size is small enough that every code from 1 to 15 can be run for at least two full tick periods, including the 16384-pulse period, with timebase pulses on every cycle. The bench also runs the idle code 0, clear strobes that coincide with ticks, a gapped timebase, fast square mode, and divider holds both between and inside runs. All of these are compared cycle by cycle against an arithmetic pulse-count model.

// File: rtl/prg_pkg.sv
package prg_pkg;

  // number of selectable divider taps for a rate code of the given width
  function automatic int taps_for(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction

  typedef struct packed {
    logic slow;   // toggles on each selected tick
    logic fast;   // toggles on each timebase pulse
  } sq_state_t;

endpackage

// File: rtl/prg_divider.sv
module prg_divider #(
  parameter int SEL_W = 4,
  localparam int NTAP = prg_pkg::taps_for(SEL_W),
  localparam int DIV_W = NTAP - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tb_en,
  input  logic            div_run,
  output logic [NTAP-1:0] carry
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // next-state: held at zero while stopped, advances only on a pulse
  always_comb begin
    cnt_d = cnt_q;
    if (!div_run) begin
      cnt_d = '0;
    end else if (tb_en) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // carry[k]: this pulse completes a group of 2^k pulses
  assign carry[0] = tb_en & div_run;

  generate
    for (genvar k = 1; k < NTAP; k++) begin : g_carry
      assign carry[k] = carry[k-1] & cnt_q[k-1];
    end
  endgenerate

endmodule

// File: rtl/prg_rate_mux.sv
module prg_rate_mux #(
  parameter int SEL_W = 4,
  localparam int NTAP = prg_pkg::taps_for(SEL_W)
) (
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [NTAP-1:0]  carry,
  output logic             tick,
  output logic             sel_zero
);

  logic [NTAP-1:0] hit;

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_hit
      assign hit[i] = (rate_sel == SEL_W'(i + 1)) & carry[i];
    end
  endgenerate

  assign tick     = |hit;
  assign sel_zero = (rate_sel == '0);

endmodule

// File: rtl/prg_flag_irq.sv
module prg_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tb_pulse,
  input  logic div_run,
  input  logic sel_zero,
  input  logic flag_clr,
  input  logic pint_en,
  input  logic sq_fast,
  output logic sq_out,
  output logic pflag,
  output logic irq
);

  import prg_pkg::*;

  logic      flag_q, flag_d;
  sq_state_t sq_q, sq_d;

  always_comb begin
    // a tick in the clear cycle must not be lost
    flag_d = tick | (flag_q & ~flag_clr);

    sq_d = sq_q;
    if (!div_run || sel_zero) begin
      sq_d.slow = 1'b0;
    end else if (tick) begin
      sq_d.slow = ~sq_q.slow;
    end
    if (!div_run) begin
      sq_d.fast = 1'b0;
    end else if (tb_pulse) begin
      sq_d.fast = ~sq_q.fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      sq_q   <= '0;
    end else begin
      flag_q <= flag_d;
      sq_q   <= sq_d;
    end
  end

  assign pflag  = flag_q;
  assign irq    = flag_q & pint_en;
  assign sq_out = sq_fast ? sq_q.fast : sq_q.slow;

endmodule

// File: rtl/prg_rate_gen.sv
module prg_rate_gen #(
  parameter int SEL_W = 4,
  localparam int NTAP = prg_pkg::taps_for(SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             div_run,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             pint_en,
  input  logic             flag_clr,
  input  logic             sq_fast,
  output logic             sq_out,
  output logic             pflag,
  output logic             irq
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [NTAP-1:0] carry_w;
  logic            tick_w;
  logic            sel_zero_w;

  prg_divider #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tb_en   (tb_en),
    .div_run (div_run),
    .carry   (carry_w)
  );

  prg_rate_mux #(.SEL_W(SEL_W)) u_mux (
    .rate_sel (rate_sel),
    .carry    (carry_w),
    .tick     (tick_w),
    .sel_zero (sel_zero_w)
  );

  prg_flag_irq u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick_w),
    .tb_pulse (carry_w[0]),
    .div_run  (div_run),
    .sel_zero (sel_zero_w),
    .flag_clr (flag_clr),
    .pint_en  (pint_en),
    .sq_fast  (sq_fast),
    .sq_out   (sq_out),
    .pflag    (pflag),
    .irq      (irq)
  );

endmodule

// File: rtl/prg_rate_gen_chk.sv
module prg_rate_gen_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_run,
  input logic [SEL_W-1:0] rate_sel,
  input logic             pint_en,
  input logic             flag_clr,
  input logic             tick,
  input logic             sq_out,
  input logic             pflag,
  input logic             irq
);

  // R6
  irq_needs_flag_and_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pflag && pint_en));

  // R4
  tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pflag);

  // R5
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tick) |=> !pflag);

  // R8
  hold_keeps_sq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_run |=> !sq_out);

  // R8
  hold_no_new_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_run && !pflag) |=> !pflag);

  // R3
  idle_code_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && !pflag) |=> !pflag);

endmodule

bind prg_rate_gen prg_rate_gen_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .div_run  (div_run),
  .rate_sel (rate_sel),
  .pint_en  (pint_en),
  .flag_clr (flag_clr),
  .tick     (tick_w),
  .sq_out   (sq_out),
  .pflag    (pflag),
  .irq      (irq)
);

// File: tb/prg_rate_gen_test.sv
module prg_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en, div_run, pint_en, flag_clr, sq_fast;
  logic [3:0] rate_sel;
  logic       sq_out, pflag, irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // bench model state
  int   mcnt;
  logic m_flag, m_slow, m_fast;

  always #5 clk = ~clk;

  prg_rate_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .div_run  (div_run),
    .rate_sel (rate_sel),
    .pint_en  (pint_en),
    .flag_clr (flag_clr),
    .sq_fast  (sq_fast),
    .sq_out   (sq_out),
    .pflag    (pflag),
    .irq      (irq)
  );

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string phase);
    logic e_sq;
    e_sq = sq_fast ? m_fast : m_slow;
    check1({phase, " R4"}, "pflag", pflag, m_flag);
    check1({phase, " R7"}, "sq_out", sq_out, e_sq);
    check1({phase, " R6"}, "irq", irq, m_flag & pint_en);
  endtask

  // one clock: model advances with the inputs present at the edge
  task automatic cyc(input string phase);
    logic pulse, tick;
    @(posedge clk);
    pulse = div_run && tb_en;
    if (!div_run) mcnt = 0;
    else if (tb_en) mcnt++;
    tick = pulse && (rate_sel != 0) && ((mcnt % (1 << (rate_sel - 1))) == 0);
    m_flag = tick | (m_flag & ~flag_clr);
    if (!div_run || rate_sel == 0) m_slow = 1'b0;
    else if (tick) m_slow = ~m_slow;
    if (!div_run) m_fast = 1'b0;
    else if (pulse) m_fast = ~m_fast;
    @(negedge clk);
    compare(phase);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tb_en = 1'b0; div_run = 1'b0; pint_en = 1'b0;
    flag_clr = 1'b0; sq_fast = 1'b0; rate_sel = 4'd0;
    mcnt = 0; m_flag = 1'b0; m_slow = 1'b0; m_fast = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in-reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R1 after-release");

    // R2 R4 R6 R7 R8: sweep every rate code, clear strobe held high
    for (int s = 1; s <= 15; s++) begin
      div_run = 1'b0; rate_sel = 4'(s); flag_clr = 1'b1;
      pint_en = s[0]; tb_en = 1'b1; sq_fast = 1'b0;
      cyc("R8 hold"); cyc("R8 hold");
      div_run = 1'b1;
      for (int c = 0; c < (1 << (s - 1)) * ((s <= 13) ? 3 : 2) + 1; c++)
        cyc("R2 sweep");
    end

    // R3: idle code
    div_run = 1'b0; cyc("R3 hold");
    rate_sel = 4'd0; div_run = 1'b1;
    for (int c = 0; c < 40; c++) cyc("R3 idle");

    // R5 R6: flag persists without clear, then clear and enable gating
    div_run = 1'b0; rate_sel = 4'd3; flag_clr = 1'b0; pint_en = 1'b1;
    cyc("R5 hold");
    div_run = 1'b1;
    for (int c = 0; c < 6; c++) cyc("R5 persist");
    pint_en = 1'b0; cyc("R6 en-low");
    pint_en = 1'b1; cyc("R6 en-high");
    div_run = 1'b0; cyc("R8 flag kept");
    cyc("R8 flag kept");
    flag_clr = 1'b1; cyc("R5 clear");
    flag_clr = 1'b0; cyc("R5 after-clear");

    // R10: gapped timebase
    rate_sel = 4'd2; div_run = 1'b1; flag_clr = 1'b1;
    for (int c = 0; c < 24; c++) begin
      tb_en = c[0];
      cyc("R10 gapped");
    end
    tb_en = 1'b1;

    // R9: fast square mode with unchanged tick timing
    div_run = 1'b0; cyc("R9 hold");
    rate_sel = 4'd3; sq_fast = 1'b1; div_run = 1'b1;
    for (int c = 0; c < 20; c++) cyc("R9 fast");
    sq_fast = 1'b0;
    for (int c = 0; c < 6; c++) cyc("R9 back-slow");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule